// File: doc/BRIEF.md
# Cross-Domain Counter Read Verifier

A free-running 16-bit counter runs on a kernel clock chosen from four sources: three independent oscillator inputs or the bus clock itself. Whenever the kernel clock is unrelated to the bus clock, a single bus-side capture of the counter can catch some bits after an update and others before it. Such a torn value must not be handed out as a good reading.

The block therefore sends the counter through a two-register capture stage into the bus domain. A bus-side verifier answers a read request only after two back-to-back stabilized samples agree. When a pair differs, the newer sample becomes the reference and the next bus cycle brings a fresh comparison. Each answer reports how many mismatched pairs came before it. After fifteen mismatches in a row the verifier gives up and flags a timeout. When the bus clock itself drives the counter no tearing is possible, so the first pair is accepted at once and the answer arrives with a fixed latency.

A bus master issues a one-cycle request. It then waits for the one-cycle valid pulse and reads the value, the mismatch count and the timeout flag in that same cycle.

Top module: `xdom_count_reader`

## Requirements
- R1: After bus reset `rd_valid`, `rd_timeout`, `rd_data` and `rd_retries` are 0. After kernel reset the counter restarts from 0, so a read taken with counting disabled returns 0.
- R2: `src_sel` picks the kernel clock: 0 = `osc_a_clk`, 1 = `osc_b_clk`, 2 = `osc_c_clk`, 3 = `bus_clk`.
- R3: The counter is 16 bits wide. It adds one on each rising kernel clock edge while `count_en` is 1 and holds while `count_en` is 0. It wraps from 0xFFFF to 0x0000, and returned values never decrease except across that wrap.
- R4: A one-cycle `rd_req` seen while the verifier is idle starts a verification. A `rd_req` seen while a verification is in progress is ignored. Each answer is a `rd_valid` pulse exactly one bus cycle wide.
- R5: A value returned with `rd_timeout` = 0 equals two consecutive stabilized samples. It is a value the counter held at some kernel cycle in the window that starts two bus cycles before the request and ends at the answer.
- R6: `rd_retries` (4 bits) gives the number of mismatched sample pairs seen before the answer. With `rd_timeout` = 0 it is below 15 for a rising `src_sel` other than 3, and the answer arrives 2 + `rd_retries` bus cycles after the request cycle.
- R7: After 15 consecutive mismatched pairs the verifier answers with `rd_timeout` = 1 and `rd_retries` = 15, 16 bus cycles after the request cycle. The returned value is then unverified.
- R8: With `src_sel` = 3 the first pair is always accepted: `rd_valid` rises exactly 2 bus cycles after the request cycle, with `rd_retries` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_a_clk | input | 1 | Kernel clock candidate, select code 0 |
| osc_b_clk | input | 1 | Kernel clock candidate, select code 1 |
| osc_c_clk | input | 1 | Kernel clock candidate, select code 2 |
| src_sel | input | 2 | Kernel clock source select (3 = bus clock); changed only while kernel reset is held |
| kern_rst_n | input | 1 | Kernel-domain reset, active low, asynchronous assert |
| count_en | input | 1 | Counter enable |
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus-domain reset, active low, asynchronous assert |
| rd_req | input | 1 | One-cycle read request |
| rd_valid | output | 1 | One-cycle answer strobe |
| rd_data | output | 16 | Returned counter value |
| rd_retries | output | 4 | Mismatched pairs seen before the answer, saturating at 15 |
| rd_timeout | output | 1 | Answer followed 15 consecutive mismatches; value unverified |

## Verification
Corrupt state in the comparison register or the mismatch counter shows up at the first answer that follows. It appears as a latency that no longer equals 2 plus the reported mismatch count, as a timeout where the kernel clock is slow, or as a value outside the counter's range during the read window. A counter that steps wrongly or ignores its enable is exposed at the next read, when the value falls outside what the bench's own edge count allows, or when two reads taken with counting stopped disagree. The bench runs the kernel at three non-integer ratios to the bus clock and at the bus clock itself, and takes one run across the 16-bit wrap.

// File: rtl/xdom_count_reader.sv
module xdom_count_reader #(
  parameter int CNT_W   = 16,
  parameter int RETRY_W = 4
) (
  input  logic               osc_a_clk,
  input  logic               osc_b_clk,
  input  logic               osc_c_clk,
  input  logic [1:0]         src_sel,
  input  logic               kern_rst_n,
  input  logic               count_en,
  input  logic               bus_clk,
  input  logic               bus_rst_n,
  input  logic               rd_req,
  output logic               rd_valid,
  output logic [CNT_W-1:0]   rd_data,
  output logic [RETRY_W-1:0] rd_retries,
  output logic               rd_timeout
);

  localparam logic [RETRY_W-1:0] MISS_MAX  = '1;
  localparam logic [RETRY_W-1:0] MISS_LAST = MISS_MAX - 1'b1;
  localparam logic [1:0]         SEL_BUS   = 2'd3;

  typedef enum logic {S_IDLE, S_CMP} vstate_t;

  logic             kern_clk;
  logic [1:0]       k_rs, b_rs;
  logic             k_live, b_live;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cap_q, stab_q, ref_q;
  logic [RETRY_W-1:0] miss_q;
  vstate_t          st_q;
  logic             sync_mode, pair_ok;

  always_comb begin
    case (src_sel)
      2'd0:    kern_clk = osc_a_clk;
      2'd1:    kern_clk = osc_b_clk;
      2'd2:    kern_clk = osc_c_clk;
      default: kern_clk = bus_clk;
    endcase
  end

  always_ff @(posedge kern_clk or negedge kern_rst_n)
    if (!kern_rst_n) k_rs <= '0;
    else             k_rs <= {k_rs[0], 1'b1};

  assign k_live = k_rs[1];

  always_ff @(posedge kern_clk or negedge kern_rst_n)
    if (!kern_rst_n)            cnt_q <= '0;
    else if (k_live && count_en) cnt_q <= cnt_q + 1'b1;

  always_ff @(posedge bus_clk or negedge bus_rst_n)
    if (!bus_rst_n) b_rs <= '0;
    else            b_rs <= {b_rs[0], 1'b1};

  assign b_live = b_rs[1];

  // raw capture may tear; second stage gives a value settled in the bus domain
  always_ff @(posedge bus_clk or negedge bus_rst_n)
    if (!bus_rst_n) begin
      cap_q  <= '0;
      stab_q <= '0;
    end else begin
      cap_q  <= cnt_q;
      stab_q <= cap_q;
    end

  assign sync_mode = (src_sel == SEL_BUS);
  assign pair_ok   = sync_mode || (stab_q == ref_q);

  always_ff @(posedge bus_clk or negedge bus_rst_n)
    if (!bus_rst_n) begin
      st_q       <= S_IDLE;
      ref_q      <= '0;
      miss_q     <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      rd_retries <= '0;
      rd_timeout <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st_q)
        S_IDLE:
          if (rd_req && b_live) begin
            ref_q  <= stab_q;
            miss_q <= '0;
            st_q   <= S_CMP;
          end
        default:
          if (pair_ok) begin
            rd_valid   <= 1'b1;
            rd_data    <= stab_q;
            rd_retries <= miss_q;
            rd_timeout <= 1'b0;
            st_q       <= S_IDLE;
          end else if (miss_q == MISS_LAST) begin
            rd_valid   <= 1'b1;
            rd_data    <= stab_q;
            rd_retries <= MISS_MAX;
            rd_timeout <= 1'b1;
            st_q       <= S_IDLE;
          end else begin
            miss_q <= miss_q + 1'b1;
            ref_q  <= stab_q;
          end
      endcase
    end

  p_cnt_step_r3: assert property (@(posedge kern_clk) disable iff (!k_live)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));

  p_cnt_hold_r3: assert property (@(posedge kern_clk) disable iff (!k_live)
    !$past(count_en) |-> $stable(cnt_q));

  p_valid_pulse_r4: assert property (@(posedge bus_clk) disable iff (!b_live)
    rd_valid |=> !rd_valid);

  p_busy_ignore_r4: assert property (@(posedge bus_clk) disable iff (!b_live)
    (st_q == S_CMP && !pair_ok && miss_q != MISS_LAST) |=> (st_q == S_CMP && !rd_valid));

  p_pair_match_r5: assert property (@(posedge bus_clk) disable iff (!b_live)
    (rd_valid && !rd_timeout && !sync_mode) |->
      (rd_data == $past(stab_q, 1) && rd_data == $past(stab_q, 2)));

  p_retry_bound_r6: assert property (@(posedge bus_clk) disable iff (!b_live)
    (rd_valid && !rd_timeout) |-> (rd_retries != MISS_MAX));

  p_timeout_count_r7: assert property (@(posedge bus_clk) disable iff (!b_live)
    (rd_valid && rd_timeout) |-> (rd_retries == MISS_MAX));

  p_sync_latency_r8: assert property (@(posedge bus_clk) disable iff (!b_live)
    (st_q == S_IDLE && rd_req && sync_mode) |-> ##2 (rd_valid && rd_retries == '0));

endmodule

// File: tb/test_xdom_count_reader.sv
`timescale 1ns/1ps
module test_xdom_count_reader;

  localparam longint SLACK = 4;

  logic        osc_a_clk = 1'b0, osc_b_clk = 1'b0, osc_c_clk = 1'b0;
  logic        bus_clk = 1'b0;
  logic [1:0]  src_sel = 2'd3;
  logic        kern_rst_n = 1'b0, bus_rst_n = 1'b0;
  logic        count_en = 1'b0;
  logic        rd_req = 1'b0;
  logic        rd_valid, rd_timeout;
  logic [15:0] rd_data;
  logic [3:0]  rd_retries;

  int total = 0, bad = 0;
  bit done = 0;

  int     edges = 0;
  longint model_u = 0;
  longint prev_u = -1;

  xdom_count_reader i_xdom_count_reader (
    .osc_a_clk(osc_a_clk), .osc_b_clk(osc_b_clk), .osc_c_clk(osc_c_clk),
    .src_sel(src_sel), .kern_rst_n(kern_rst_n), .count_en(count_en),
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_retries(rd_retries),
    .rd_timeout(rd_timeout));

  always #5    bus_clk   = ~bus_clk;
  always #11.5 osc_a_clk = ~osc_a_clk;
  always #18.5 osc_b_clk = ~osc_b_clk;
  always #3.5  osc_c_clk = ~osc_c_clk;

  task automatic tick();
    if (kern_rst_n) begin
      edges++;
      if (edges >= 3 && count_en) model_u++;
    end
  endtask

  always @(posedge osc_a_clk) if (src_sel == 2'd0) tick();
  always @(posedge osc_b_clk) if (src_sel == 2'd1) tick();
  always @(posedge osc_c_clk) if (src_sel == 2'd2) tick();
  always @(posedge bus_clk)   if (src_sel == 2'd3) tick();

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic kreset(input logic [1:0] sel, input logic en);
    @(negedge bus_clk);
    kern_rst_n = 1'b0;
    count_en   = en;
    repeat (3) @(negedge bus_clk);
    src_sel = sel;
    edges   = 0;
    model_u = 0;
    prev_u  = -1;
    repeat (3) @(negedge bus_clk);
    kern_rst_n = 1'b1;
    repeat (4) @(negedge bus_clk);
  endtask

  task automatic do_read(output logic [15:0] d, output int r, output bit to,
                         output int lat, output longint lo, output longint hi);
    @(negedge bus_clk);
    rd_req = 1'b1;
    lo = model_u;
    @(negedge bus_clk);
    rd_req = 1'b0;
    lat = 1;
    while (!rd_valid && lat < 40) begin
      @(negedge bus_clk);
      lat++;
    end
    d  = rd_data;
    r  = int'(rd_retries);
    to = rd_timeout;
    hi = model_u;
    chk(rd_valid, "R4", "answer arrived", lat, 40);
  endtask

  function automatic longint place(input logic [15:0] d, input longint lo, input longint hi);
    for (longint v = lo - SLACK; v <= hi; v++)
      if (v >= 0 && v[15:0] == d) return v;
    return -1;
  endfunction

  task automatic check_value(input string req, input logic [15:0] d,
                             input longint lo, input longint hi);
    longint u;
    u = place(d, lo, hi);
    chk(u >= 0, req, "value within read window", longint'(d), hi);
    chk(u >= prev_u, "R3", "no decrease except at wrap", u, prev_u);
    if (u >= 0) prev_u = u;
  endtask

  task automatic t_reset();
    logic [15:0] d; int r, lat; bit to; longint lo, hi;
    chk(rd_valid == 1'b0,   "R1", "valid after reset", rd_valid, 0);
    chk(rd_timeout == 1'b0, "R1", "timeout after reset", rd_timeout, 0);
    chk(rd_data == 16'h0,   "R1", "data after reset", rd_data, 0);
    chk(rd_retries == 4'h0, "R1", "retries after reset", rd_retries, 0);
    kreset(2'd3, 1'b0);
    do_read(d, r, to, lat, lo, hi);
    chk(d == 16'h0, "R1", "counter restarts at zero", d, 0);
    chk(r == 0,     "R8", "retries in bus-clock mode", r, 0);
    chk(lat == 2,   "R8", "bus-clock mode latency", lat, 2);
  endtask

  task automatic t_sync_latency();
    logic [15:0] d; int r, lat; bit to; longint lo, hi;
    kreset(2'd3, 1'b1);
    for (int i = 0; i < 4; i++) begin
      repeat (3 + i) @(negedge bus_clk);
      do_read(d, r, to, lat, lo, hi);
      chk(lat == 2,  "R8", "bus-clock mode latency", lat, 2);
      chk(r == 0,    "R8", "bus-clock mode retries", r, 0);
      chk(to == 1'b0, "R8", "no timeout in bus-clock mode", to, 0);
      check_value("R2", d, lo, hi);
    end
  endtask

  task automatic t_ratio(input logic [1:0] sel);
    logic [15:0] d; int r, lat; bit to; longint lo, hi;
    kreset(sel, 1'b1);
    for (int i = 0; i < 10; i++) begin
      repeat (5 + 3 * i) @(negedge bus_clk);
      do_read(d, r, to, lat, lo, hi);
      chk(to == 1'b0,      "R6", "no timeout with slow kernel", to, 0);
      chk(r < 15,          "R6", "retry count below limit", r, 14);
      chk(lat == 2 + r,    "R6", "latency equals 2 plus retries", lat, 2 + r);
      check_value("R5", d, lo, hi);
    end
  endtask

  task automatic t_hold();
    logic [15:0] d1, d2; int r, lat; bit to; longint lo, hi;
    kreset(2'd0, 1'b1);
    repeat (40) @(negedge bus_clk);
    count_en = 1'b0;
    repeat (10) @(negedge bus_clk);
    do_read(d1, r, to, lat, lo, hi);
    check_value("R3", d1, lo, hi);
    chk(d1 != 16'h0, "R3", "counter advanced while enabled", d1, 1);
    repeat (60) @(negedge bus_clk);
    do_read(d2, r, to, lat, lo, hi);
    chk(d2 == d1, "R3", "counter holds while disabled", d2, d1);
    count_en = 1'b1;
  endtask

  task automatic t_ignore();
    int pulses = 0;
    kreset(2'd3, 1'b1);
    @(negedge bus_clk);
    rd_req = 1'b1;
    @(negedge bus_clk);
    rd_req = 1'b1;
    @(negedge bus_clk);
    rd_req = 1'b0;
    chk(rd_valid == 1'b1, "R4", "first request answered", rd_valid, 1);
    for (int i = 0; i < 6; i++) begin
      if (rd_valid) pulses++;
      @(negedge bus_clk);
    end
    chk(pulses == 1, "R4", "busy request ignored, one pulse", pulses, 1);
  endtask

  task automatic t_timeout();
    logic [15:0] d; int r, lat; bit to; longint lo, hi;
    kreset(2'd2, 1'b1);
    repeat (5) @(negedge bus_clk);
    do_read(d, r, to, lat, lo, hi);
    chk(to == 1'b1, "R7", "timeout flag with fast kernel", to, 1);
    chk(r == 15,    "R7", "retries saturate at 15", r, 15);
    chk(lat == 16,  "R7", "timeout latency", lat, 16);
    @(negedge bus_clk);
    chk(rd_valid == 1'b0, "R4", "valid one cycle wide", rd_valid, 0);
  endtask

  task automatic t_wrap();
    logic [15:0] d; int r, lat; bit to; longint lo, hi;
    bit saw_high = 0, saw_wrap = 0;
    kreset(2'd3, 1'b1);
    while (model_u < 65525) @(negedge bus_clk);
    for (int i = 0; i < 8; i++) begin
      do_read(d, r, to, lat, lo, hi);
      check_value("R3", d, lo, hi);
      if (d >= 16'hFFF0) saw_high = 1;
      if (saw_high && d < 16'h0010) saw_wrap = 1;
    end
    chk(saw_wrap, "R3", "wrap from 0xFFFF to 0 observed", saw_wrap, 1);
  endtask

  initial begin
    repeat (4) @(negedge bus_clk);
    bus_rst_n = 1'b1;
    repeat (4) @(negedge bus_clk);
    t_reset();
    t_sync_latency();
    t_ratio(2'd0);
    t_ratio(2'd1);
    t_hold();
    t_ignore();
    t_timeout();
    t_wrap();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule